// File: doc/BRIEF.md
# Serial Register Access Port

This block is the slave side of a four-wire serial host port. A controller pulls chip select low, clocks in one command byte and then moves data bytes to or from a bank of eleven 8-bit registers. Every byte travels least significant bit first. The command byte picks the direction and a 4-bit register address. It also carries a burst flag that walks the whole bank in order when the address is zero. The register bank sits outside the block. The port reaches it through a write strobe with address and data, and through a combinational read address and read data pair.

All serial inputs are brought into the system clock domain by a parameterised synchronizer. The block then works on the detected edges of the serial clock. Input bits are taken on rising serial clock edges. Output bits are launched on falling edges, and the output enable is low whenever the port is not reading, so the data-in and data-out lines can share one host pin. Two of the registers are status registers. A complete single read of either one raises a one-cycle clear request that the line-side logic uses to reset that register. A burst read never raises it.

Top module: `ser_reg_port`

## Requirements
- R1: The command byte is shifted LSB first. Its bit 0 is the direction (1 = read, 0 = write), bits 4..1 are the register address with bit 4 as the MSB, bits 6..5 are reserved, and bit 7 is the burst flag.
- R2: After a write command, the next 8 rising serial clock edges shift in a data byte LSB first. When the eighth bit arrives, `reg_wr_en` pulses for one clock with `reg_wr_addr` set to the addressed register and `reg_wr_data` set to the byte.
- R3: After a read command, the addressed register appears on `sdo` LSB first, one bit per falling serial clock edge for 8 edges, with `sdo_oe` high.
- R4: `sdo_oe` is low after reset, while chip select is high, during the command byte, and throughout every write transfer.
- R5: With the burst flag set and address 0, consecutive bytes access registers 0, 1, 2 and so on in order. After the last register the port ignores the serial clock (no write, `sdo_oe` low) until chip select rises.
- R6: With the burst flag set and a nonzero address, the transfer is a single access. Bytes after the first are ignored.
- R7: Addresses 11 to 15 are unimplemented. A write to one of them produces no `reg_wr_en`, and a read returns 0x00.
- R8: A command byte with either reserved bit set makes the port ignore the rest of the transfer. No write happens, no clear request is raised, and `sdo_oe` stays low.
- R9: A chip select rise ends the transfer and discards a partial data byte. This holds even when the rise is seen in the same cycle as the eighth rising clock edge. The next transfer then works normally.
- R10: A completed single read of status register A (address 9) or B (address 10) pulses `stat_clr[0]` or `stat_clr[1]` respectively for exactly one clock. Burst reads and reads of other registers raise no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | Output enable for the `sdo` pad driver |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_addr | output | 4 | Register write address |
| reg_wr_data | output | 8 | Register write data |
| reg_rd_addr | output | 4 | Register read address |
| reg_rd_data | input | 8 | Register read data, combinational from `reg_rd_addr` |
| stat_clr | output | 2 | Clear-after-read pulses for status registers A and B |

## Verification
Two events can land in the same system clock cycle: the detected eighth rising clock edge of a data byte, which would commit a write, and the detected chip select rise, which aborts the transfer. The bench provokes this by driving `sclk` high and `cs_n` high in the same time step after seven data bits. Both inputs pass through synchronizers of equal depth, so the two edges surface together. The result is judged at the ports: no `reg_wr_en` pulse may appear, and a later single read must return the register's old value. A normal write right after the abort must then succeed.

// File: rtl/ser_reg_port_pkg.sv
package ser_reg_port_pkg;

   localparam int CMD_W      = 8;
   localparam int CMD_ADDR_W = 4;

   typedef enum logic [1:0] {
      ST_CMD,
      ST_WR,
      ST_RD,
      ST_HALT
   } port_state_e;

   typedef struct packed {
      logic                  burst;
      logic [1:0]            rsvd;
      logic [CMD_ADDR_W-1:0] addr;
      logic                  rd;
   } cmd_byte_t;

endpackage

// File: rtl/ser_reg_port_sync.sv
module ser_reg_port_sync #(
   parameter int            STAGES    = 2,
   parameter int            WIDTH     = 3,
   parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] stage_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stage_q[i] <= RESET_VAL;
            end else begin
               stage_q[0] <= d;
               for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
            end
         end
         assign q = stage_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/ser_reg_port_decode.sv
module ser_reg_port_decode
   import ser_reg_port_pkg::*;
#(
   parameter int NUM_REGS = 11
) (
   input  logic [CMD_W-1:0]      cmd_raw,
   output logic                  is_read,
   output logic [CMD_ADDR_W-1:0] addr,
   output logic                  burst_on,
   output logic                  legal
);

   cmd_byte_t cmd;

   always_comb begin
      cmd      = cmd_byte_t'(cmd_raw);
      is_read  = cmd.rd;
      addr     = cmd.addr;
      legal    = (cmd.rsvd == 2'b00);
      burst_on = cmd.burst && (cmd.addr == '0);
   end

endmodule

// File: rtl/ser_reg_port_engine.sv
module ser_reg_port_engine
   import ser_reg_port_pkg::*;
#(
   parameter int NUM_REGS    = 11,
   parameter int STAT_A_ADDR = 9,
   parameter int STAT_B_ADDR = 10
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cs_n_s,
   input  logic                  sclk_s,
   input  logic                  sdi_s,
   output logic                  sdo,
   output logic                  sdo_oe,
   output logic                  wr_en,
   output logic [CMD_ADDR_W-1:0] wr_addr,
   output logic [CMD_W-1:0]      wr_data,
   output logic [CMD_ADDR_W-1:0] rd_addr,
   input  logic [CMD_W-1:0]      rd_data,
   output logic [1:0]            stat_clr
);

   localparam int AW    = CMD_ADDR_W;
   localparam int DW    = CMD_W;
   localparam int CNT_W = $clog2(DW);
   localparam logic [AW:0]    NREG_L  = (AW+1)'(NUM_REGS);
   localparam logic [AW-1:0]  LAST_A  = AW'(NUM_REGS - 1);
   localparam logic [AW-1:0]  STAT_A  = AW'(STAT_A_ADDR);
   localparam logic [AW-1:0]  STAT_B  = AW'(STAT_B_ADDR);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DW - 1);

   port_state_e      state;
   logic             sclk_d;
   logic [CNT_W-1:0] bcnt;
   logic [DW-2:0]    shreg;
   logic [AW-1:0]    addr_q;
   logic             burst_q;
   logic [DW-1:0]    tx_q;

   logic             rise, fall, last_bit, addr_ok;
   logic [DW-1:0]    incoming, rd_val;
   logic             dec_rd, dec_burst, dec_legal;
   logic [AW-1:0]    dec_addr;

   assign rise     = sclk_s & ~sclk_d;
   assign fall     = ~sclk_s & sclk_d;
   assign incoming = {sdi_s, shreg};
   assign last_bit = (bcnt == LAST_BIT);
   assign addr_ok  = ({1'b0, addr_q} < NREG_L);
   assign rd_addr  = addr_q;
   assign rd_val   = addr_ok ? rd_data : '0;

   ser_reg_port_decode #(.NUM_REGS(NUM_REGS)) u_decode (
      .cmd_raw  (incoming),
      .is_read  (dec_rd),
      .addr     (dec_addr),
      .burst_on (dec_burst),
      .legal    (dec_legal)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_CMD;
         sclk_d   <= 1'b1;
         bcnt     <= '0;
         shreg    <= '0;
         addr_q   <= '0;
         burst_q  <= 1'b0;
         tx_q     <= '0;
         sdo      <= 1'b0;
         sdo_oe   <= 1'b0;
         wr_en    <= 1'b0;
         wr_addr  <= '0;
         wr_data  <= '0;
         stat_clr <= '0;
      end else begin
         sclk_d   <= sclk_s;
         wr_en    <= 1'b0;
         stat_clr <= '0;
         if (cs_n_s) begin
            // deselect wins over any edge seen in the same cycle
            state   <= ST_CMD;
            bcnt    <= '0;
            burst_q <= 1'b0;
            sdo_oe  <= 1'b0;
         end else begin
            if (rise) begin
               shreg <= incoming[DW-1:1];
               bcnt  <= bcnt + 1'b1;
               if (last_bit) begin
                  unique case (state)
                     ST_CMD: begin
                        if (!dec_legal) begin
                           state <= ST_HALT;
                        end else begin
                           addr_q  <= dec_addr;
                           burst_q <= dec_burst;
                           state   <= dec_rd ? ST_RD : ST_WR;
                        end
                     end
                     ST_WR, ST_RD: begin
                        if (state == ST_WR && addr_ok) begin
                           wr_en   <= 1'b1;
                           wr_addr <= addr_q;
                           wr_data <= incoming;
                        end
                        if (state == ST_RD && !burst_q) begin
                           stat_clr[0] <= (addr_q == STAT_A);
                           stat_clr[1] <= (addr_q == STAT_B);
                        end
                        if (burst_q && addr_q != LAST_A) begin
                           addr_q <= addr_q + 1'b1;
                        end else begin
                           state <= ST_HALT;
                        end
                     end
                     default: ;
                  endcase
               end
            end
            if (fall) begin
               if (state == ST_RD) begin
                  sdo_oe <= 1'b1;
                  if (bcnt == '0) begin
                     sdo  <= rd_val[0];
                     tx_q <= rd_val;
                  end else begin
                     sdo <= tx_q[bcnt];
                  end
               end else begin
                  sdo_oe <= 1'b0;
               end
            end
         end
      end
   end

   // ---------------- assertions ----------------
   assert_hiz_deselected_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_s |=> !sdo_oe);

   assert_no_drive_in_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WR) |-> !sdo_oe);

   assert_write_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> ({1'b0, wr_addr} < NREG_L));

   assert_commit_after_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> ($past(rise) && !$past(cs_n_s)));

   assert_clear_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(stat_clr));

   assert_clear_single_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_clr != 2'b00) |=> (stat_clr == 2'b00));

   assert_burst_no_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      burst_q |-> (stat_clr == 2'b00));

   assert_halt_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state) == ST_HALT) |-> !wr_en);

endmodule

// File: rtl/ser_reg_port.sv
module ser_reg_port
   import ser_reg_port_pkg::*;
#(
   parameter int NUM_REGS    = 11,
   parameter int STAT_A_ADDR = 9,
   parameter int STAT_B_ADDR = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n,
   input  logic       sclk,
   input  logic       sdi,
   output logic       sdo,
   output logic       sdo_oe,
   output logic       reg_wr_en,
   output logic [3:0] reg_wr_addr,
   output logic [7:0] reg_wr_data,
   output logic [3:0] reg_rd_addr,
   input  logic [7:0] reg_rd_data,
   output logic [1:0] stat_clr
);

   localparam int MAX_REGS = 1 << CMD_ADDR_W;

   generate
      if (NUM_REGS < 1 || NUM_REGS > MAX_REGS) begin : g_bad_nregs
         $error("ser_reg_port: NUM_REGS must lie in 1..%0d", MAX_REGS);
      end
      if (STAT_A_ADDR >= NUM_REGS || STAT_B_ADDR >= NUM_REGS) begin : g_bad_stat
         $error("ser_reg_port: status addresses must be implemented registers");
      end
      if (STAT_A_ADDR == STAT_B_ADDR) begin : g_same_stat
         $error("ser_reg_port: status addresses must differ");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("ser_reg_port: SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic [2:0] pins_s;

   ser_reg_port_sync #(
      .STAGES    (SYNC_STAGES),
      .WIDTH     (3),
      .RESET_VAL (3'b110)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cs_n, sclk, sdi}),
      .q     (pins_s)
   );

   ser_reg_port_engine #(
      .NUM_REGS    (NUM_REGS),
      .STAT_A_ADDR (STAT_A_ADDR),
      .STAT_B_ADDR (STAT_B_ADDR)
   ) u_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_n_s   (pins_s[2]),
      .sclk_s   (pins_s[1]),
      .sdi_s    (pins_s[0]),
      .sdo      (sdo),
      .sdo_oe   (sdo_oe),
      .wr_en    (reg_wr_en),
      .wr_addr  (reg_wr_addr),
      .wr_data  (reg_wr_data),
      .rd_addr  (reg_rd_addr),
      .rd_data  (reg_rd_data),
      .stat_clr (stat_clr)
   );

endmodule

// File: tb/ser_reg_port_bench.sv
module ser_reg_port_bench;

   localparam int H     = 6;   // system clocks per serial half period
   localparam int NREGS = 11;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1, sclk = 1'b1, sdi = 1'b0;
   logic       sdo, sdo_oe, reg_wr_en;
   logic [3:0] reg_wr_addr, reg_rd_addr;
   logic [7:0] reg_wr_data, reg_rd_data;
   logic [1:0] stat_clr;

   logic [7:0] bank [16];
   logic [7:0] expv [16];
   int checks = 0, errors = 0;
   int wr_cnt = 0, clr_a = 0, clr_b = 0;
   logic [3:0] last_wa;
   logic [7:0] last_wd;
   bit done = 0;

   always #10 clk = ~clk;

   assign reg_rd_data = bank[reg_rd_addr];

   ser_reg_port u_ser_reg_port (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
      .sdo(sdo), .sdo_oe(sdo_oe), .reg_wr_en(reg_wr_en),
      .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
      .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
      .stat_clr(stat_clr)
   );

   // bank model and port monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (reg_wr_en) begin
            wr_cnt++;
            last_wa = reg_wr_addr;
            last_wd = reg_wr_data;
            bank[reg_wr_addr] = reg_wr_data;
         end
         if (stat_clr[0]) clr_a++;
         if (stat_clr[1]) clr_b++;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [7:0] mk_cmd(input bit rd, input int addr,
                                         input bit burst, input int rsvd);
      return {burst, 2'(rsvd), 4'(addr), rd};
   endfunction

   task automatic begin_xfer();
      cs_n = 1'b0;
      wait_clk(H);
   endtask

   task automatic end_xfer();
      sclk = 1'b1;
      cs_n = 1'b1;
      wait_clk(2*H);
   endtask

   task automatic shift_bits(input logic [7:0] tx, input int n,
                             output logic [7:0] rx, output bit oe_any, output bit oe_all);
      rx = '0; oe_any = 0; oe_all = 1;
      for (int i = 0; i < n; i++) begin
         sclk = 1'b0;
         sdi  = tx[i];
         wait_clk(H);
         rx[i]  = sdo;
         oe_any = oe_any | sdo_oe;
         oe_all = oe_all & sdo_oe;
         sclk = 1'b1;
         wait_clk(H);
      end
   endtask

   task automatic single_write(input int addr, input logic [7:0] d, output bit oe_any);
      logic [7:0] rx; bit a1, a2, b1, b2;
      begin_xfer();
      shift_bits(mk_cmd(0, addr, 0, 0), 8, rx, a1, b1);
      shift_bits(d, 8, rx, a2, b2);
      end_xfer();
      oe_any = a1 | a2;
   endtask

   task automatic single_read(input int addr, output logic [7:0] d, output bit oe_all);
      logic [7:0] rx; bit a1, b1, a2;
      begin_xfer();
      shift_bits(mk_cmd(1, addr, 0, 0), 8, rx, a1, b1);
      shift_bits(8'h00, 8, d, a2, oe_all);
      end_xfer();
   endtask

   initial begin : main
      logic [7:0] rx, d;
      bit oa, ol;
      int w0, ca, cb;

      for (int i = 0; i < 16; i++) begin
         bank[i] = 8'((i * 29 + 7) & 8'hFF);
         expv[i] = (i < NREGS) ? bank[i] : 8'h00;
      end
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(3);

      // reset state
      check(sdo_oe == 1'b0, "R4", "sdo_oe after reset", sdo_oe, 0);
      check(reg_wr_en == 1'b0, "R2", "wr_en after reset", reg_wr_en, 0);
      check(stat_clr == 2'b00, "R10", "stat_clr after reset", stat_clr, 0);

      // R1 R3 R7 R10: single read sweep over every address
      for (int a = 0; a < 16; a++) begin
         ca = clr_a; cb = clr_b;
         single_read(a, d, ol);
         check(d == expv[a], (a < NREGS) ? "R3" : "R7", $sformatf("read addr %0d", a), d, expv[a]);
         check(ol == 1'b1, "R3", $sformatf("sdo_oe during read %0d", a), ol, 1);
         check(clr_a - ca == ((a == 9) ? 1 : 0), "R10", $sformatf("clear A after read %0d", a), clr_a - ca, (a == 9) ? 1 : 0);
         check(clr_b - cb == ((a == 10) ? 1 : 0), "R10", $sformatf("clear B after read %0d", a), clr_b - cb, (a == 10) ? 1 : 0);
      end

      // R2 R4 R7: single write sweep, then read back
      for (int a = 0; a < 16; a++) begin
         logic [7:0] v;
         v = 8'((a * 53 + 11) & 8'hFF);
         w0 = wr_cnt;
         single_write(a, v, oa);
         check(oa == 1'b0, "R4", $sformatf("sdo_oe during write %0d", a), oa, 0);
         if (a < NREGS) begin
            expv[a] = v;
            check(wr_cnt - w0 == 1, "R2", $sformatf("write pulses addr %0d", a), wr_cnt - w0, 1);
            check(last_wa == 4'(a) && last_wd == v, "R2", $sformatf("write addr/data %0d", a), {last_wa, last_wd}, {4'(a), v});
         end else begin
            check(wr_cnt - w0 == 0, "R7", $sformatf("write pulses addr %0d", a), wr_cnt - w0, 0);
         end
      end
      for (int a = 0; a < 16; a++) begin
         single_read(a, d, ol);
         check(d == expv[a], "R2", $sformatf("readback addr %0d", a), d, expv[a]);
      end

      // R5: burst write of every register plus two surplus bytes
      w0 = wr_cnt;
      begin_xfer();
      shift_bits(mk_cmd(0, 0, 1, 0), 8, rx, oa, ol);
      for (int i = 0; i < NREGS + 2; i++) begin
         logic [7:0] v;
         v = 8'((8'hC3 ^ (i * 17)) & 8'hFF);
         shift_bits(v, 8, rx, oa, ol);
         if (i < NREGS) expv[i] = v;
         check(oa == 1'b0, "R5", $sformatf("sdo_oe in burst write byte %0d", i), oa, 0);
      end
      end_xfer();
      check(wr_cnt - w0 == NREGS, "R5", "burst write pulses", wr_cnt - w0, NREGS);
      check(last_wa == 4'(NREGS - 1), "R5", "burst last write address", last_wa, NREGS - 1);

      // R5 R10: burst read walks the bank, no clears, then goes quiet
      ca = clr_a; cb = clr_b;
      begin_xfer();
      shift_bits(mk_cmd(1, 0, 1, 0), 8, rx, oa, ol);
      for (int i = 0; i < NREGS + 2; i++) begin
         shift_bits(8'h00, 8, rx, oa, ol);
         if (i < NREGS) begin
            check(rx == expv[i] && ol, "R5", $sformatf("burst read byte %0d", i), rx, expv[i]);
         end else begin
            check(oa == 1'b0, "R5", $sformatf("sdo_oe after burst end %0d", i), oa, 0);
         end
      end
      end_xfer();
      check(clr_a == ca && clr_b == cb, "R10", "no clear on burst read", clr_a + clr_b, ca + cb);

      // R6: burst flag with nonzero address is a single access
      begin_xfer();
      shift_bits(mk_cmd(1, 3, 1, 0), 8, rx, oa, ol);
      shift_bits(8'h00, 8, d, oa, ol);
      check(d == expv[3], "R6", "burst flag addr 3 first byte", d, expv[3]);
      shift_bits(8'h00, 8, d, oa, ol);
      check(oa == 1'b0, "R6", "burst flag addr 3 second byte oe", oa, 0);
      end_xfer();
      w0 = wr_cnt;
      begin_xfer();
      shift_bits(mk_cmd(0, 4, 1, 0), 8, rx, oa, ol);
      shift_bits(8'h5A, 8, rx, oa, ol);
      shift_bits(8'hA5, 8, rx, oa, ol);
      end_xfer();
      expv[4] = 8'h5A;
      check(wr_cnt - w0 == 1 && last_wa == 4'd4 && last_wd == 8'h5A, "R6", "burst flag addr 4 write", wr_cnt - w0, 1);

      // R8: reserved bits set
      for (int r = 1; r < 4; r++) begin
         w0 = wr_cnt;
         begin_xfer();
         shift_bits(mk_cmd(0, 2, 0, r), 8, rx, oa, ol);
         shift_bits(8'hEE, 8, rx, oa, ol);
         end_xfer();
         check(wr_cnt == w0, "R8", $sformatf("write ignored rsvd %0d", r), wr_cnt - w0, 0);
         ca = clr_a;
         begin_xfer();
         shift_bits(mk_cmd(1, 9, 0, r), 8, rx, oa, ol);
         shift_bits(8'h00, 8, rx, oa, ol);
         end_xfer();
         check(oa == 1'b0, "R8", $sformatf("read ignored rsvd %0d", r), oa, 0);
         check(clr_a == ca, "R8", $sformatf("no clear rsvd %0d", r), clr_a - ca, 0);
      end
      single_read(2, d, ol);
      check(d == expv[2], "R8", "register 2 untouched", d, expv[2]);

      // R9: abort mid-byte
      w0 = wr_cnt;
      begin_xfer();
      shift_bits(mk_cmd(0, 5, 0, 0), 8, rx, oa, ol);
      shift_bits(8'hFF, 4, rx, oa, ol);
      end_xfer();
      check(wr_cnt == w0, "R9", "partial byte discarded", wr_cnt - w0, 0);

      // R9: chip select rise coincides with eighth rising edge
      begin_xfer();
      shift_bits(mk_cmd(0, 5, 0, 0), 8, rx, oa, ol);
      shift_bits(8'h81, 7, rx, oa, ol);
      sclk = 1'b0; sdi = 1'b1;
      wait_clk(H);
      sclk = 1'b1; cs_n = 1'b1;
      wait_clk(2*H);
      check(wr_cnt == w0, "R9", "coincident deselect discards", wr_cnt - w0, 0);
      single_read(5, d, ol);
      check(d == expv[5], "R9", "register 5 unchanged", d, expv[5]);
      single_write(5, 8'h3C, oa);
      expv[5] = 8'h3C;
      single_read(5, d, ol);
      check(d == 8'h3C, "R9", "write after abort", d, 8'h3C);

      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule